// File: doc/BRIEF.md
# Flash Program/Erase Unlock Controller

This block sits between a CPU register bus and a flash array and makes sure that no program or erase pulse reaches the array unless software has first walked a keyed unlock sequence. Software names the target page, writes two key bytes in a fixed order, and then names the same page again. Only then will a page erase, a mass erase or a byte program be passed on to the array as a single-cycle command. Any stray or out-of-order write drops the controller back to the locked state.

A per-sector write-once protect mask shares the bus address of the page register. A dedicated control command redirects that address to the mask. Pages in a protected sector can never be unlocked, and a mass erase is refused while any protect bit is set. A 16-bit frequency value, loaded through two byte registers, goes to the array so that it can time its pulses. An operation is refused while that value is zero. While the array works, the CPU is stalled. When the array reports completion, the controller relocks and releases the stall.

Top module: `flash_guard_ctrl`

## Requirements
- R1: After reset the status code (read data bits [5:0] at register address 0) is 000000, cpu_stall is low, no command output is high, and the frequency reads back as zero.
- R2: Writing the page register (address 1), then 73H and then 8CH to the control register (address 0), then the same page value again, steps the status through 000000, 000001, 000010 and ends at 000011 (unlocked).
- R3: A key byte that is wrong, repeated or out of order returns the status to 000000. The first key is also refused unless a page write came before it.
- R4: If the second page write differs from the first, the status returns to 000000.
- R5: The sector of a page is its top three page bits. A matching page in a sector whose protect bit is set leaves the status at 000000.
- R6: Writing 5EH to the control register selects the protect mask (status 000100), and address 1 then reads the mask. The next address-1 write ORs its low eight bits into the mask and returns to locked. Protect bits are never cleared except by reset.
- R7: While unlocked, a control write other than 95H or 63H relocks, and so does a page register write.
- R8: While unlocked with a nonzero frequency, writing 95H issues a one-cycle cmd_page_erase with cmd_page equal to the unlocked page. cpu_stall then stays high and the status reads 001000 until arr_done, after which the status is 000000 and cpu_stall is low.
- R9: Writing 63H while unlocked issues cmd_mass_erase only when the protect mask is all zero. Otherwise no command is issued and the status returns to 000000.
- R10: While unlocked, a write to the data register (address 4) issues a one-cycle cmd_prog that carries the written byte on cmd_data and the unlocked page on cmd_page.
- R11: The frequency is written as a high byte at address 2 and a low byte at address 3, and it reads back at the same addresses and drives op_freq. While it is zero, any program or erase request is refused and relocks without issuing a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 8 | Read data (combinational) |
| arr_done | input | 1 | Array reports the current operation finished |
| cmd_prog | output | 1 | One-cycle byte-program command |
| cmd_page_erase | output | 1 | One-cycle page-erase command |
| cmd_mass_erase | output | 1 | One-cycle mass-erase command |
| cmd_page | output | 7 | Target page of the command |
| cmd_data | output | 8 | Byte to program |
| op_freq | output | 16 | Frequency value for pulse timing |
| cpu_stall | output | 1 | Holds the CPU while an operation runs |

## Verification
The hardest case to reach is a fully correct key sequence that still fails because of state built up earlier: a page in a sector that was protected several transactions before, or a mass erase after one sector bit was set. The stimulus first runs clean operations while the mask is empty. It then sets a protect bit through the redirected address, retries unlocks on pages inside and outside that sector, and a scoreboard confirms that only the allowed commands ever reach the array.

// File: rtl/flash_guard_ctrl.sv
module flash_guard_ctrl #(
  parameter int PAGE_W = 7,
  parameter int SECT_W = 3,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] KEY_A      = 8'h73,
  parameter logic [DATA_W-1:0] KEY_B      = 8'h8C,
  parameter logic [DATA_W-1:0] CMD_PERASE = 8'h95,
  parameter logic [DATA_W-1:0] CMD_MERASE = 8'h63,
  parameter logic [DATA_W-1:0] CMD_PROT   = 8'h5E
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [2:0]          wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [2:0]          rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  input  logic                arr_done,
  output logic                cmd_prog,
  output logic                cmd_page_erase,
  output logic                cmd_mass_erase,
  output logic [PAGE_W-1:0]   cmd_page,
  output logic [DATA_W-1:0]   cmd_data,
  output logic [2*DATA_W-1:0] op_freq,
  output logic                cpu_stall
);
  localparam int NSECT = 1 << SECT_W;
  localparam int FREQ_W = 2 * DATA_W;
  localparam logic [2:0] A_CTRL = 3'd0, A_PAGE = 3'd1, A_FHI = 3'd2, A_FLO = 3'd3, A_PDAT = 3'd4;

  typedef enum logic [2:0] {ST_LOCK, ST_KEY1, ST_KEY2, ST_UNLK, ST_PROT, ST_BUSY} st_t;

  st_t               st;
  logic              armed;
  logic [PAGE_W-1:0] page_q;
  logic [NSECT-1:0]  prot_q;
  logic [FREQ_W-1:0] freq_q;
  logic [5:0]        stat_code;

  wire ctrl_wr = wr_en && wr_addr == A_CTRL;
  wire page_wr = wr_en && wr_addr == A_PAGE;
  wire pdat_wr = wr_en && wr_addr == A_PDAT;
  wire freq_ok = freq_q != '0;
  wire [PAGE_W-1:0] wr_page = wr_data[PAGE_W-1:0];
  wire [SECT_W-1:0] wr_sect = wr_page[PAGE_W-1 -: SECT_W];

  always_comb begin
    case (st)
      ST_KEY1: stat_code = 6'b000001;
      ST_KEY2: stat_code = 6'b000010;
      ST_UNLK: stat_code = 6'b000011;
      ST_PROT: stat_code = 6'b000100;
      ST_BUSY: stat_code = 6'b001000;
      default: stat_code = 6'b000000;
    endcase
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = DATA_W'(stat_code);
      A_PAGE:  rd_data = (st == ST_PROT) ? DATA_W'(prot_q) : DATA_W'(page_q);
      A_FHI:   rd_data = freq_q[FREQ_W-1:DATA_W];
      A_FLO:   rd_data = freq_q[DATA_W-1:0];
      default: rd_data = '0;
    endcase
  end

  assign cmd_page  = page_q;
  assign op_freq   = freq_q;
  assign cpu_stall = st == ST_BUSY;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_LOCK;
      armed <= 1'b0;
      page_q <= '0;
      prot_q <= '0;
      freq_q <= '0;
      cmd_data <= '0;
      cmd_prog <= 1'b0;
      cmd_page_erase <= 1'b0;
      cmd_mass_erase <= 1'b0;
    end else begin
      cmd_prog <= 1'b0;
      cmd_page_erase <= 1'b0;
      cmd_mass_erase <= 1'b0;
      if (wr_en && wr_addr == A_FHI) freq_q[FREQ_W-1:DATA_W] <= wr_data;
      if (wr_en && wr_addr == A_FLO) freq_q[DATA_W-1:0] <= wr_data;
      if (st != ST_LOCK) armed <= 1'b0;
      case (st)
        ST_LOCK: begin
          if (page_wr) begin
            page_q <= wr_page;
            armed <= 1'b1;
          end else if (ctrl_wr || pdat_wr) begin
            armed <= 1'b0;
            if (ctrl_wr && wr_data == KEY_A && armed) st <= ST_KEY1;
            else if (ctrl_wr && wr_data == CMD_PROT) st <= ST_PROT;
          end
        end
        ST_KEY1: begin
          if (ctrl_wr && wr_data == KEY_B) st <= ST_KEY2;
          else if (ctrl_wr || page_wr || pdat_wr) st <= ST_LOCK;
        end
        ST_KEY2: begin
          if (page_wr && wr_page == page_q && !prot_q[wr_sect]) st <= ST_UNLK;
          else if (ctrl_wr || page_wr || pdat_wr) st <= ST_LOCK;
        end
        ST_UNLK: begin
          if (ctrl_wr && wr_data == CMD_PERASE && freq_ok) begin
            st <= ST_BUSY;
            cmd_page_erase <= 1'b1;
          end else if (ctrl_wr && wr_data == CMD_MERASE && freq_ok && prot_q == '0) begin
            st <= ST_BUSY;
            cmd_mass_erase <= 1'b1;
          end else if (pdat_wr && freq_ok) begin
            st <= ST_BUSY;
            cmd_prog <= 1'b1;
            cmd_data <= wr_data;
          end else if (ctrl_wr || page_wr || pdat_wr) st <= ST_LOCK;
        end
        ST_PROT: begin
          if (page_wr) prot_q <= prot_q | NSECT'(wr_data);
          if (ctrl_wr || page_wr || pdat_wr) st <= ST_LOCK;
        end
        ST_BUSY: if (arr_done) st <= ST_LOCK;
        default: st <= ST_LOCK;
      endcase
    end
  end
endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk #(
  parameter int NSECT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_prog,
  input logic             cmd_page_erase,
  input logic             cmd_mass_erase,
  input logic             cpu_stall,
  input logic             arr_done,
  input logic [15:0]      op_freq,
  input logic [NSECT-1:0] prot,
  input logic [5:0]       stat
);
  wire any_cmd = cmd_prog | cmd_page_erase | cmd_mass_erase;

  AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({cmd_prog, cmd_page_erase, cmd_mass_erase})); // R8
  AST_CMD_STALLS: assert property (@(posedge clk) disable iff (!rst_n) any_cmd |-> cpu_stall); // R8
  AST_DONE_RELOCK: assert property (@(posedge clk) disable iff (!rst_n) (cpu_stall && arr_done) |=> (stat == 6'd0 && !cpu_stall)); // R8
  AST_MERASE_NOPROT: assert property (@(posedge clk) disable iff (!rst_n) cmd_mass_erase |-> prot == '0); // R9
  AST_PROT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (prot & $past(prot)) == $past(prot)); // R6
  AST_ERASE_FROM_UNLK: assert property (@(posedge clk) disable iff (!rst_n) cmd_page_erase |-> $past(stat) == 6'd3); // R2
  AST_FREQ_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) any_cmd |-> op_freq != '0); // R11
endmodule

bind flash_guard_ctrl flash_guard_chk #(.NSECT(NSECT)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_prog(cmd_prog), .cmd_page_erase(cmd_page_erase),
  .cmd_mass_erase(cmd_mass_erase), .cpu_stall(cpu_stall), .arr_done(arr_done),
  .op_freq(op_freq), .prot(prot_q), .stat(stat_code)
);

// File: tb/flash_guard_ctrl_tb_top.sv
module flash_guard_ctrl_tb_top;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data, cmd_data;
  logic arr_done, cmd_prog, cmd_page_erase, cmd_mass_erase, cpu_stall;
  logic [6:0] cmd_page;
  logic [15:0] op_freq;
  int total = 0, bad = 0;
  bit finished = 0;
  logic [3:0] busy_cnt = 0;
  logic [32:0] exp_q[$];

  always #5 clk = ~clk;

  flash_guard_ctrl dut_i (.*);

  assign arr_done = busy_cnt == 4'd1;
  always @(posedge clk) begin
    if (cmd_prog || cmd_page_erase || cmd_mass_erase) busy_cnt <= 4'd4;
    else if (busy_cnt != 0) busy_cnt <= busy_cnt - 4'd1;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected commands when the design issues one
  always @(negedge clk) begin
    if (rst_n && (cmd_prog || cmd_page_erase || cmd_mass_erase)) begin
      logic [32:0] got;
      got = {cmd_mass_erase ? 2'd3 : cmd_page_erase ? 2'd2 : 2'd1, cmd_page,
             cmd_prog ? cmd_data : 8'h00, op_freq};
      if (exp_q.size() == 0) chk("R8 unexpected command", 32'(got[32:16]), 32'h0);
      else begin
        logic [32:0] e;
        e = exp_q.pop_front();
        chk("R8/R9/R10 command", 32'(got[32:16]), 32'(e[32:16]));
        chk("R11 op_freq", 32'(got[15:0]), 32'(e[15:0]));
      end
    end
  end

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic chk_stat(string req, logic [5:0] exp);
    logic [7:0] d;
    rd(3'd0, d);
    chk(req, 32'(d), 32'(exp));
  endtask

  task automatic unlock(logic [6:0] pg, logic [5:0] final_stat);
    wr(3'd1, {1'b0, pg}); chk_stat("R2 after page", 6'd0);
    wr(3'd0, 8'h73);      chk_stat("R2 after key1", 6'd1);
    wr(3'd0, 8'h8C);      chk_stat("R2 after key2", 6'd2);
    wr(3'd1, {1'b0, pg}); chk_stat("R2/R5 after page again", final_stat);
  endtask

  task automatic wait_idle();
    while (cpu_stall) @(negedge clk);
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_stat("R1 reset status", 6'd0);
    chk("R1 reset stall", 32'(cpu_stall), 0);
    chk("R1 no command", 32'({cmd_prog, cmd_page_erase, cmd_mass_erase}), 0);
    rd(3'd2, d); chk("R1 freq hi", 32'(d), 0);

    // R11: zero frequency refuses an erase
    unlock(7'h05, 6'd3);
    wr(3'd0, 8'h95); chk_stat("R11 refused with zero freq", 6'd0);
    chk("R11 no stall", 32'(cpu_stall), 0);
    wr(3'd2, 8'h12); wr(3'd3, 8'h34);
    rd(3'd2, d); chk("R11 freq hi", 32'(d), 32'h12);
    rd(3'd3, d); chk("R11 freq lo", 32'(d), 32'h34);

    // R8 page erase
    unlock(7'h05, 6'd3);
    exp_q.push_back({2'd2, 7'h05, 8'h00, 16'h1234});
    wr(3'd0, 8'h95);
    chk("R8 stall during erase", 32'(cpu_stall), 1);
    chk_stat("R8 busy status", 6'b001000);
    wait_idle();
    chk_stat("R8 relocked after done", 6'd0);

    // R10 byte program
    unlock(7'h10, 6'd3);
    exp_q.push_back({2'd1, 7'h10, 8'hA5, 16'h1234});
    wr(3'd4, 8'hA5);
    wait_idle();
    chk_stat("R10 relocked after program", 6'd0);

    // R9 mass erase allowed with empty mask
    unlock(7'h22, 6'd3);
    exp_q.push_back({2'd3, 7'h22, 8'h00, 16'h1234});
    wr(3'd0, 8'h63);
    wait_idle();
    chk_stat("R9 relocked after mass erase", 6'd0);

    // R3 ordering faults
    wr(3'd1, 8'h03); wr(3'd0, 8'h8C); chk_stat("R3 key2 first", 6'd0);
    wr(3'd0, 8'h73); chk_stat("R3 key1 without page", 6'd0);
    wr(3'd1, 8'h03); wr(3'd0, 8'h73); chk_stat("R3 key1 ok", 6'd1);
    wr(3'd0, 8'h73); chk_stat("R3 repeated key1", 6'd0);
    wr(3'd1, 8'h03); wr(3'd0, 8'h72); chk_stat("R3 wrong key", 6'd0);

    // R4 mismatched page
    wr(3'd1, 8'h07); wr(3'd0, 8'h73); wr(3'd0, 8'h8C); wr(3'd1, 8'h08);
    chk_stat("R4 page mismatch", 6'd0);

    // R7 relock
    unlock(7'h09, 6'd3);
    wr(3'd0, 8'h11); chk_stat("R7 stray control write", 6'd0);
    unlock(7'h09, 6'd3);
    wr(3'd1, 8'h09); chk_stat("R7 page write relocks", 6'd0);

    // R6 protect mask
    wr(3'd0, 8'h5E); chk_stat("R6 protect selected", 6'd4);
    wr(3'd1, 8'h04); chk_stat("R6 back to locked", 6'd0);
    wr(3'd0, 8'h5E); rd(3'd1, d); chk("R6 mask reads", 32'(d), 32'h04);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h5E); rd(3'd1, d); chk("R6 mask not cleared", 32'(d), 32'h04);
    wr(3'd0, 8'h00); chk_stat("R6 exit by control write", 6'd0);

    // R5 protected sector 2 (pages 20H..2FH)
    unlock(7'h20, 6'd0);
    unlock(7'h2F, 6'd0);
    unlock(7'h30, 6'd3);
    // R9 refused with mask set
    wr(3'd0, 8'h63); chk_stat("R9 refused mass erase", 6'd0);
    chk("R9 no stall", 32'(cpu_stall), 0);
    unlock(7'h30, 6'd3);
    exp_q.push_back({2'd2, 7'h30, 8'h00, 16'h1234});
    wr(3'd0, 8'h95);
    wait_idle();
    chk_stat("R5 unprotected sector erased", 6'd0);

    repeat (3) @(negedge clk);
    chk("R8 all expected commands seen", 32'(exp_q.size()), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule